// File: doc/BRIEF.md
# NAND ECC Engine Register Front-End

This block is the register face of a NAND error-correction engine. Software reaches it through a 32-bit register bus with per-byte write enables and a combinational read port. The control word has no direct write address: its bits are raised through a set alias and lowered through a clear alias. A count word holds two lengths, one for encoding and one for decoding. The decoding length covers the data bytes followed by the parity bytes.

Bytes are pushed one at a time into a data port. The block counts them against the length that the current mode selects. One cycle after the final byte, it raises an encode-finished or decode-finished flag in a write-1-to-clear status word. The correction arithmetic is replaced by a stub. The stub folds every accepted byte into a 32-bit accumulator. Parity words, error flags, error counts and error bit indices are all derived from that accumulator, so software can exercise the full read-back sequence.

An interrupt line reports any status flag whose enable bit is set. The enable bits have their own read address plus set and clear aliases.

Top module: `ecc_regfront`

## Requirements
- R1: After reset the control, count, status and interrupt-enable words read 0 and `irq` is 0.
- R2: Control (read 0x00) bits: 0 enable, 1 init, 2 strength (1 = high), 3 mode (1 = encode, 0 = decode). Writing 0x04 sets the bits given as 1 and writing 0x08 clears them. Zero bits and bytes whose enable is low leave the bits unchanged.
- R3: A set of the init bit reads back as 1 for exactly one cycle and then clears itself. While it is set, the byte counter, the accumulator and the all-0xFF/all-0x00 trackers return to their start values.
- R4: Count word 0x0C holds the encode length in bits 9:0 and the decode length in bits 25:16. It is written per byte lane, and every other bit reads 0.
- R5: A write to data port 0x10 with byte enable 0 set supplies byte wdata[7:0]. The byte is accepted only when enable is 1, init is 0 and fewer bytes than the active length have been taken. Other writes change neither the result nor the status.
- R6: Each accepted byte b updates the accumulator to acc = rotl(acc,1) ^ b. Encode-finished (status bit 2) is raised in the second cycle after the final byte's write edge.
- R7: Parity word k at 0x14+4k reads rotl(acc,8k). This holds for k < 4 at high strength and for k < 2 at low strength; other parity words read 0.
- R8: Decode completion sets bit 3. If all bytes were 0xFF only bit 4 is added; if all bytes were 0x00 only bit 5 is added. Otherwise a nonzero acc sets bit 0. When acc[31]=1 it also sets bit 1; when acc[31]=0 it puts acc[2:0]+1 into bits 31:28 and bits 22:16.
- R9: The all-0xFF (bit 4) and all-0x00 (bit 5) flags take precedence over the error flags.
- R10: Error-index word j at 0x28+4j holds index 2j in bits 12:0 and index 2j+1 in bits 28:16. Index i is (syn[15:3] + 37*i) mod 8192, where syn is acc captured at decode completion.
- R11: Writing 0x24 clears exactly the status bits written as 1 in enabled lanes. A completion in the same cycle still sets its bits.
- R12: Interrupt enables (read 0x38, set 0x3C, clear 0x40) mask status bits 5:0. `irq` is 1 exactly when an enabled status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Masked OR of the status flags |

## Verification
Register writes show on the read port at the first sampling point after the write edge. The init bit is visible only in that sample and is gone one cycle later. Parity words follow the accumulator one cycle after each accepted byte. The finished flags, error fields and index words arrive one cycle later still, so the bench reads status both straight after the final byte write (expecting the flag low) and one clock after (expecting it high). All reads happen at the falling edge, after combinational settling. `irq` is checked in the same sample as the status and enable writes that drive it.

// File: rtl/ecc_regfront.sv
module ecc_regfront #(
  parameter int AW        = 8,
  parameter int CNT_W     = 10,
  parameter int PAR_WORDS = 4,
  parameter int IDX_WORDS = 4,
  parameter int IDX_W     = 13,
  parameter int IDX_STEP  = 37
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [3:0]    bus_be,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam int A_CTRL = 'h00, A_SET = 'h04, A_CLR = 'h08, A_CNT = 'h0C;
  localparam int A_DATA = 'h10, A_PAR = 'h14, A_STAT = 'h24, A_IDX = 'h28;
  localparam int A_IEN  = 'h38, A_ISET = 'h3C, A_ICLR = 'h40;
  localparam int LO_WORDS = PAR_WORDS / 2;

  logic [3:0]       ctrl;
  logic [CNT_W-1:0] enc_len, dec_len, cnt;
  logic [31:0]      acc, syn, status, st_nxt;
  logic [5:0]       inte;
  logic             allf, all0, done_p, done_enc;

  function automatic logic [31:0] rotl(input logic [31:0] v, input int s);
    return (v << s) | (v >> (32 - s));
  endfunction

  function automatic logic [IDX_W-1:0] idx(input logic [31:0] s, input int i);
    return IDX_W'(s[IDX_W+2:3] + IDX_W'(IDX_STEP * i));
  endfunction

  wire [31:0] bm = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
  wire [31:0] wv = bus_wdata & bm;
  wire hit_set  = bus_wr && int'(bus_addr) == A_SET;
  wire hit_clr  = bus_wr && int'(bus_addr) == A_CLR;
  wire hit_cnt  = bus_wr && int'(bus_addr) == A_CNT;
  wire hit_stat = bus_wr && int'(bus_addr) == A_STAT;
  wire hit_iset = bus_wr && int'(bus_addr) == A_ISET;
  wire hit_iclr = bus_wr && int'(bus_addr) == A_ICLR;

  wire [CNT_W-1:0] limit = ctrl[3] ? enc_len : dec_len;
  wire accept = bus_wr && int'(bus_addr) == A_DATA && bus_be[0] &&
                ctrl[0] && !ctrl[1] && cnt < limit;
  wire last   = accept && ({1'b0, cnt} + 1'b1) == {1'b0, limit};
  wire [7:0] din = bus_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      inte <= '0;
      enc_len <= '0;
      dec_len <= '0;
    end else begin
      ctrl <= (({ctrl[3:2], 1'b0, ctrl[0]}) | (hit_set ? wv[3:0] : 4'h0))
              & ~(hit_clr ? wv[3:0] : 4'h0);
      inte <= (inte | (hit_iset ? wv[5:0] : 6'h0)) & ~(hit_iclr ? wv[5:0] : 6'h0);
      if (hit_cnt) begin
        for (int b = 0; b < CNT_W; b++) begin
          if (bus_be[b/8]) enc_len[b] <= bus_wdata[b];
          if (bus_be[2 + b/8]) dec_len[b] <= bus_wdata[16+b];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
      allf <= 1'b1;
      all0 <= 1'b1;
      done_p <= 1'b0;
      done_enc <= 1'b0;
    end else begin
      done_p <= last;
      if (last) done_enc <= ctrl[3];
      if (ctrl[1]) begin
        cnt <= '0;
        acc <= '0;
        allf <= 1'b1;
        all0 <= 1'b1;
      end else if (accept) begin
        cnt <= cnt + 1'b1;
        acc <= rotl(acc, 1) ^ {24'h0, din};
        allf <= allf && din == 8'hFF;
        all0 <= all0 && din == 8'h00;
      end
    end
  end

  always_comb begin
    st_nxt = status & ~(hit_stat ? wv : 32'h0);
    if (done_p) begin
      if (done_enc) st_nxt[2] = 1'b1;
      else begin
        st_nxt[3] = 1'b1;
        st_nxt[31:28] = 4'h0;
        st_nxt[22:16] = 7'h0;
        if (allf) st_nxt[4] = 1'b1;
        else if (all0) st_nxt[5] = 1'b1;
        else if (acc != 0) begin
          st_nxt[0] = 1'b1;
          if (acc[31]) st_nxt[1] = 1'b1;
          else begin
            st_nxt[31:28] = {1'b0, acc[2:0]} + 4'h1;
            st_nxt[22:16] = {3'b0, acc[2:0]} + 7'h1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      syn <= '0;
    end else begin
      status <= st_nxt;
      if (done_p && !done_enc) syn <= acc;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (int'(bus_addr) == A_CTRL) bus_rdata = {28'h0, ctrl};
    if (int'(bus_addr) == A_CNT)
      bus_rdata = {{(16-CNT_W){1'b0}}, dec_len, {(16-CNT_W){1'b0}}, enc_len};
    if (int'(bus_addr) == A_STAT) bus_rdata = status;
    if (int'(bus_addr) == A_IEN) bus_rdata = {26'h0, inte};
    for (int k = 0; k < PAR_WORDS; k++)
      if (int'(bus_addr) == A_PAR + 4*k && (ctrl[2] || k < LO_WORDS))
        bus_rdata = rotl(acc, 8*k);
    for (int j = 0; j < IDX_WORDS; j++)
      if (int'(bus_addr) == A_IDX + 4*j)
        bus_rdata = {{(16-IDX_W){1'b0}}, idx(syn, 2*j+1), {(16-IDX_W){1'b0}}, idx(syn, 2*j)};
  end

  assign irq = |(status[5:0] & inte);
endmodule

// File: rtl/ecc_regfront_chk.sv
module ecc_regfront_chk #(
  parameter int AW    = 8,
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       ctrl,
  input logic [CNT_W-1:0] cnt,
  input logic [31:0]      status,
  input logic [5:0]       inte,
  input logic             irq,
  input logic             done_p,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [3:0]       bus_be,
  input logic [31:0]      bus_wdata
);
  a_r3_init_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[1] |=> !ctrl[1]);
  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !ctrl[1]) |=> $stable(cnt));
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(done_p));
  a_r8_uncor_has_err: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> status[0]);
  a_r11_w1c_all: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && int'(bus_addr) == 'h24 && bus_be == 4'hF &&
     bus_wdata == 32'hFFFF_FFFF && !done_p) |=> status == 32'h0);
  a_r12_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (inte == 6'h0) |-> !irq);
endmodule

bind ecc_regfront ecc_regfront_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .cnt(cnt), .status(status),
  .inte(inte), .irq(irq), .done_p(done_p), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata)
);

// File: tb/tb_ecc_regfront.sv
module tb_ecc_regfront;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, irq;
  logic [7:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int checks = 0, errors = 0;
  logic [7:0] bytes [64];

  ecc_regfront dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rotl(input logic [31:0] v, input int s);
    return (v << s) | (v >> (32 - s));
  endfunction

  function automatic logic [31:0] model_acc(input int n);
    logic [31:0] a = 0;
    for (int i = 0; i < n; i++) a = rotl(a, 1) ^ {24'h0, bytes[i]};
    return a;
  endfunction

  function automatic logic [31:0] exp_dec(input int n);
    logic [31:0] a = model_acc(n), s = 32'h8;
    logic ff = 1, z = 1;
    for (int i = 0; i < n; i++) begin
      ff &= bytes[i] == 8'hFF;
      z &= bytes[i] == 8'h00;
    end
    if (ff) s |= 32'h10;
    else if (z) s |= 32'h20;
    else if (a != 0) begin
      s |= 32'h1;
      if (a[31]) s |= 32'h2;
      else s |= ({29'h0, a[2:0]} + 1) << 28 | ({29'h0, a[2:0]} + 1) << 16;
    end
    return s;
  endfunction

  function automatic logic [31:0] exp_idx(input logic [31:0] a, input int j);
    logic [12:0] i0 = a[15:3] + 13'(37 * (2*j));
    logic [12:0] i1 = a[15:3] + 13'(37 * (2*j + 1));
    return {3'h0, i1, 3'h0, i0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic start(input bit enc, input bit s8, input int n);
    wr(8'h24, 32'hFFFF_FFFF, 4'hF);
    wr(8'h0C, enc ? 32'(n) | 32'h5_0000 : (32'(n) << 16) | 32'h5, 4'hF);
    wr(8'h08, 32'hF, 4'h1);
    wr(8'h04, {28'h0, enc, s8, 2'b11}, 4'h1);
    @(negedge clk);
  endtask

  task automatic push(input int n, input string req);
    logic [31:0] v;
    for (int i = 0; i < n; i++) wr(8'h10, {24'h0, bytes[i]}, 4'h1);
    rd(8'h24, v);
    chk({req, " done not yet"}, v & 32'hC, 32'h0);
    @(negedge clk);
  endtask

  task automatic check_parity(input int n, input bit s8, input string req);
    logic [31:0] v, a = model_acc(n);
    for (int k = 0; k < 4; k++) begin
      rd(8'(8'h14 + 4*k), v);
      chk(req, v, (s8 || k < 2) ? rotl(a, 8*k) : 32'h0);
    end
  endtask

  task automatic run_dec(input int n, input string req);
    logic [31:0] v, a;
    start(1'b0, 1'b1, n);
    push(n, req);
    rd(8'h24, v);
    chk({req, " R8 status"}, v, exp_dec(n));
    a = model_acc(n);
    for (int j = 0; j < 4; j++) begin
      rd(8'(8'h28 + 4*j), v);
      chk("R10 index word", v, exp_idx(a, j));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, st;
    int n;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h0C, v); chk("R1 count", v, 0);
    rd(8'h24, v); chk("R1 status", v, 0);
    rd(8'h38, v); chk("R1 inte", v, 0);
    chk("R1 irq", irq, 0);

    wr(8'h04, 32'h5, 4'h1); rd(8'h00, v); chk("R2 set", v, 32'h5);
    wr(8'h08, 32'h1, 4'h1); rd(8'h00, v); chk("R2 clear", v, 32'h4);
    wr(8'h04, 32'hF, 4'h0); rd(8'h00, v); chk("R2 lane off", v, 32'h4);
    wr(8'h04, 32'h2, 4'h1); rd(8'h00, v); chk("R3 init visible", v, 32'h6);
    @(negedge clk); rd(8'h00, v); chk("R3 init self-clear", v, 32'h4);
    wr(8'h08, 32'hF, 4'h1);

    wr(8'h0C, 32'hFFFF_FFFF, 4'hF); rd(8'h0C, v); chk("R4 count fields", v, 32'h03FF_03FF);
    wr(8'h0C, 32'h00AB_0000, 4'h4); rd(8'h0C, v); chk("R4 count lane", v, 32'h03AB_03FF);

    wr(8'h0C, 32'h2, 4'hF);
    wr(8'h04, 32'hA, 4'h1);
    @(negedge clk);
    wr(8'h10, 32'h11, 4'h1); wr(8'h10, 32'h22, 4'h1);
    @(negedge clk); @(negedge clk);
    rd(8'h24, v); chk("R5 disabled no done", v, 0);
    rd(8'h14, v); chk("R5 disabled no acc", v, 0);
    bytes[0] = 8'h5A; bytes[1] = 8'hC3;
    wr(8'h04, 32'h1, 4'h1);
    wr(8'h10, 32'h5A, 4'h1);
    wr(8'h10, 32'h7E, 4'h0);
    wr(8'h10, 32'hC3, 4'h1);
    rd(8'h24, v); chk("R6 timing not yet", v, 0);
    @(negedge clk);
    rd(8'h24, v); chk("R6 encode done", v, 32'h4);
    wr(8'h10, 32'h99, 4'h1);
    check_parity(2, 1'b0, "R5 extra byte ignored");

    for (int r = 0; r < 6; r++) begin
      bit s8 = 1'($urandom);
      n = 1 + int'($urandom % 40);
      for (int i = 0; i < n; i++) bytes[i] = 8'($urandom);
      start(1'b1, s8, n);
      push(n, "R6");
      rd(8'h24, v); chk("R6 encode flag", v, 32'h4);
      check_parity(n, s8, s8 ? "R7 parity high" : "R7 parity low");
    end

    for (int r = 0; r < 6; r++) begin
      n = 2 + int'($urandom % 50);
      for (int i = 0; i < n; i++) bytes[i] = 8'($urandom);
      run_dec(n, "R8 random");
    end

    for (int i = 0; i < 8; i++) bytes[i] = 8'hFF;
    run_dec(8, "R9 all ff");
    for (int i = 0; i < 8; i++) bytes[i] = 8'h00;
    run_dec(8, "R9 all zero");
    bytes[0] = 8'h01; bytes[1] = 8'h02;
    run_dec(2, "R8 zero syndrome");
    bytes[0] = 8'h01;
    for (int i = 1; i < 32; i++) bytes[i] = 8'h00;
    run_dec(32, "R8 uncorrectable");
    bytes[0] = 8'h03; bytes[1] = 8'h00; bytes[2] = 8'h10;
    run_dec(3, "R8 correctable");

    rd(8'h24, st);
    wr(8'h3C, 32'h08, 4'h1);
    rd(8'h38, v); chk("R12 inte set", v, 32'h08);
    chk("R12 irq on", irq, 1);
    wr(8'h24, 32'h08, 4'h1);
    rd(8'h24, v); chk("R11 w1c one bit", v, st & ~32'h8);
    chk("R12 irq off", irq, 0);
    wr(8'h24, st, 4'h8);
    rd(8'h24, v); chk("R11 w1c lane", v, st & ~32'hFF00_0008);
    wr(8'h40, 32'h08, 4'h1);
    rd(8'h38, v); chk("R12 inte clear", v, 0);

    for (int i = 0; i < 5; i++) bytes[i] = 8'($urandom);
    start(1'b1, 1'b1, 5);
    wr(8'h10, 32'hAA, 4'h1); wr(8'h10, 32'hBB, 4'h1); wr(8'h10, 32'hCC, 4'h1);
    wr(8'h04, 32'h2, 4'h1);
    @(negedge clk);
    push(5, "R3 restart");
    check_parity(5, 1'b1, "R3 restart parity");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule